// File: doc/BRIEF.md
# Draw Coalescing Enable Policy Controller

This block decides, one frame at a time, whether a draw-coalescing filter elsewhere in the pipeline should be active. At the end of each frame, a single-cycle strobe delivers two counts. The first is the frame's total draw count. The second is the number of draws the filter managed to collapse. The controller then moves between an enabled and a disabled state and keeps a two-bit hint that records why it is disabled. It also pulses a clear signal that tells the filter to zero its per-frame counters.

The policy has hysteresis. Coalescing is switched on only when the draw pressure is high, meaning more than 2000 draws in a frame. It is switched off again when it collapses fewer than 500 draws in a frame. It is also switched off when the original submission (draws plus collapsed draws) turns out to be light. Once a disable leaves the hint at "unoptimizable", the block does not try again until a light frame resets the hint to "low load". A force-off pulse marks the workload as incompatible. That state is sticky until reset.

Top module: `coalesce_policy`

## Requirements
- R1: After reset, en_o is 0, hint_o is 0 (none) and clr_o is 0. Hint codes are: 0 none, 1 low load, 2 unoptimizable, 3 incompatible.
- R2: A force_off_i pulse while enabled produces, on the next clock, en_o=0, hint_o=3 and a one-cycle clr_o. A force_off_i pulse while disabled changes nothing. When force_off_i and frame_end_i arrive in the same cycle, the force-off alone is acted on.
- R3: While disabled with hint 3, frame ends change nothing.
- R4: While disabled with a hint other than 3, a frame with draw_i <= 2000 sets hint_o to 1 and the block stays disabled.
- R5: While disabled with hint 2, a frame with draw_i > 2000 changes nothing.
- R6: While disabled with hint 0 or 1, a frame with draw_i > 2000 sets en_o to 1 and leaves the hint unchanged.
- R7: While enabled, a frame with collapsed_i < 500 disables the block with hint 2.
- R8: While enabled, a frame where draw_i + collapsed_i is at most 2000 disables the block with hint 1. The sum is formed without wrap-around. This outcome takes priority over R7.
- R9: While enabled, a frame that meets neither R7 nor R8 leaves the block enabled with its hint unchanged.
- R10: Every frame evaluated while enabled raises clr_o for exactly one cycle. Outputs change on the clock after the strobe and hold when there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end_i | input | 1 | Single-cycle frame-end strobe |
| draw_i | input | 32 | Total draws in the frame just ended |
| collapsed_i | input | 32 | Draws collapsed by the filter in that frame |
| force_off_i | input | 1 | Force-disable pulse |
| en_o | output | 1 | Coalescing enable |
| hint_o | output | 2 | Policy hint code |
| clr_o | output | 1 | One-cycle counter clear for the filter |

## Verification
The bench targets the exact thresholds:
- A draw count of exactly 2000 against 2001. A design that used a strict compare would re-enable on a light frame.
- 499 against 500 collapsed draws. An off-by-one compare here would drop a working filter.
- A frame that is both light and low-benefit. A design with the wrong priority would report unoptimizable and never retry.

It also drives sums that overflow 32 bits. A wrapped adder would falsely see a light frame.

Finally, it checks the stickiness of the two hints. A design that let frame ends clear the incompatible state, or re-enable from unoptimizable, would diverge from the bench's reference model.

// File: rtl/coalesce_policy_pkg.sv
package coalesce_policy_pkg;
  typedef enum logic [1:0] {
    HINT_NONE     = 2'd0,
    HINT_LOW_LOAD = 2'd1,
    HINT_UNOPT    = 2'd2,
    HINT_INCOMPAT = 2'd3
  } hint_e;

  typedef struct packed {
    logic  en;
    hint_e hint;
    logic  clr;
  } policy_t;
endpackage

// File: rtl/coalesce_policy_cmp.sv
module coalesce_policy_cmp #(
  parameter int CNT_W          = 32,
  parameter int PRESSURE_LIMIT = 2000,
  parameter int BENEFIT_MIN    = 500
) (
  input  logic [CNT_W-1:0] draw_i,
  input  logic [CNT_W-1:0] collapsed_i,
  output logic             draw_light_o,
  output logic             total_light_o,
  output logic             benefit_poor_o
);
  localparam int SUM_W = CNT_W + 1;
  typedef logic [SUM_W-1:0] wide_t;

  localparam wide_t PRESS_W   = wide_t'(PRESSURE_LIMIT);
  localparam wide_t BENEFIT_W = wide_t'(BENEFIT_MIN);

  wide_t draw_ext, coll_ext, total;

  always_comb begin
    draw_ext       = {1'b0, draw_i};
    coll_ext       = {1'b0, collapsed_i};
    total          = draw_ext + coll_ext;
    draw_light_o   = (draw_ext <= PRESS_W);
    total_light_o  = (total <= PRESS_W);
    benefit_poor_o = (coll_ext < BENEFIT_W);
  end
endmodule

// File: rtl/coalesce_policy_decide.sv
module coalesce_policy_decide
  import coalesce_policy_pkg::*;
(
  input  policy_t cur_i,
  input  logic    frame_end_i,
  input  logic    force_off_i,
  input  logic    draw_light_i,
  input  logic    total_light_i,
  input  logic    benefit_poor_i,
  output policy_t nxt_o
);
  always_comb begin
    nxt_o     = cur_i;
    nxt_o.clr = 1'b0;
    if (force_off_i) begin
      if (cur_i.en) begin
        nxt_o.en   = 1'b0;
        nxt_o.hint = HINT_INCOMPAT;
        nxt_o.clr  = 1'b1;
      end
    end else if (frame_end_i) begin
      if (cur_i.en) begin
        nxt_o.clr = 1'b1;
        if (total_light_i) begin
          nxt_o.en   = 1'b0;
          nxt_o.hint = HINT_LOW_LOAD;
        end else if (benefit_poor_i) begin
          nxt_o.en   = 1'b0;
          nxt_o.hint = HINT_UNOPT;
        end
      end else if (cur_i.hint != HINT_INCOMPAT) begin
        if (draw_light_i) begin
          nxt_o.hint = HINT_LOW_LOAD;
        end else if (cur_i.hint != HINT_UNOPT) begin
          nxt_o.en = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coalesce_policy.sv
module coalesce_policy
  import coalesce_policy_pkg::*;
#(
  parameter int CNT_W          = 32,
  parameter int PRESSURE_LIMIT = 2000,
  parameter int BENEFIT_MIN    = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] draw_i,
  input  logic [CNT_W-1:0] collapsed_i,
  input  logic             force_off_i,
  output logic             en_o,
  output logic [1:0]       hint_o,
  output logic             clr_o
);
  policy_t cur_q, nxt;
  logic    draw_light, total_light, benefit_poor;
  logic    state_ce;

  coalesce_policy_cmp #(
    .CNT_W(CNT_W), .PRESSURE_LIMIT(PRESSURE_LIMIT), .BENEFIT_MIN(BENEFIT_MIN)
  ) u_cmp (
    .draw_i(draw_i), .collapsed_i(collapsed_i),
    .draw_light_o(draw_light), .total_light_o(total_light),
    .benefit_poor_o(benefit_poor)
  );

  coalesce_policy_decide u_decide (
    .cur_i(cur_q), .frame_end_i(frame_end_i), .force_off_i(force_off_i),
    .draw_light_i(draw_light), .total_light_i(total_light),
    .benefit_poor_i(benefit_poor), .nxt_o(nxt)
  );

  assign state_ce = frame_end_i | force_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q.en   <= 1'b0;
      cur_q.hint <= HINT_NONE;
    end else if (state_ce) begin
      cur_q.en   <= nxt.en;
      cur_q.hint <= nxt.hint;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q.clr <= 1'b0;
    else        cur_q.clr <= nxt.clr;
  end

  assign en_o   = cur_q.en;
  assign hint_o = cur_q.hint;
  assign clr_o  = cur_q.clr;

  // R2: force-off while enabled lands in the incompatible state with a clear
  a_r2_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off_i && en_o) |=> (!en_o && hint_o == 2'd3 && clr_o));

  // R3: the incompatible state is sticky while disabled
  a_r3_incompat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && hint_o == 2'd3) |=> (!en_o && hint_o == 2'd3));

  // R8: a light total wins over poor benefit
  a_r8_light_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && frame_end_i && !force_off_i && total_light) |=> (!en_o && hint_o == 2'd1));

  // R7: poor benefit disables
  a_r7_poor_benefit: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && frame_end_i && !force_off_i && benefit_poor) |=> !en_o);

  // R10: a clear pulse only follows a cycle spent enabled, and lasts one cycle
  a_r10_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> $past(en_o));
  a_r10_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> (!clr_o || $past(en_o)));

  // R10: without a strobe the state holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end_i && !force_off_i) |=> ($stable(en_o) && $stable(hint_o) && !clr_o));

  // R6: the enabled state never carries the incompatible hint
  a_r6_no_incompat_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> hint_o != 2'd3);
endmodule

// File: tb/coalesce_policy_test.sv
`timescale 1ns/1ps
module coalesce_policy_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_end_i, force_off_i;
  logic [31:0] draw_i, collapsed_i;
  logic        en_o, clr_o;
  logic [1:0]  hint_o;

  int checks = 0;
  int failures = 0;
  bit m_en;
  logic [1:0] m_hint;
  bit m_clr;
  string m_tag;

  always #2 clk = ~clk;

  coalesce_policy uut (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end_i), .draw_i(draw_i),
    .collapsed_i(collapsed_i), .force_off_i(force_off_i),
    .en_o(en_o), .hint_o(hint_o), .clr_o(clr_o)
  );

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Reference policy, written from the requirements
  function automatic void model(bit fe, bit fo, logic [31:0] d, logic [31:0] c);
    longint unsigned tot = longint'(d) + longint'(c);
    m_clr = 0;
    m_tag = "R10";
    if (fo) begin
      m_tag = "R2";
      if (m_en) begin m_en = 0; m_hint = 2'd3; m_clr = 1; end
    end else if (fe) begin
      if (m_en) begin
        m_clr = 1;
        if (tot <= 2000) begin m_en = 0; m_hint = 2'd1; m_tag = "R8"; end
        else if (c < 500) begin m_en = 0; m_hint = 2'd2; m_tag = "R7"; end
        else m_tag = "R9";
      end else if (m_hint == 2'd3) m_tag = "R3";
      else if (d <= 2000) begin m_hint = 2'd1; m_tag = "R4"; end
      else if (m_hint == 2'd2) m_tag = "R5";
      else begin m_en = 1; m_tag = "R6"; end
    end
  endfunction

  task automatic compare(string tag);
    checks++;
    if (en_o !== m_en || hint_o !== m_hint || clr_o !== m_clr) begin
      failures++;
      $display("FAIL %s en/hint/clr actual=%0b/%0d/%0b expected=%0b/%0d/%0b",
               tag, en_o, hint_o, clr_o, m_en, m_hint, m_clr);
    end
  endtask

  task automatic step(bit fe, bit fo, logic [31:0] d, logic [31:0] c);
    @(negedge clk);
    frame_end_i = fe; force_off_i = fo; draw_i = d; collapsed_i = c;
    model(fe, fo, d, c);
    @(negedge clk);
    frame_end_i = 0; force_off_i = 0;
    compare(m_tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_en = 0; m_hint = 2'd0; m_clr = 0;
    @(negedge clk);
    rst_n = 1;
    compare("R1");
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'd1995 + $urandom_range(0, 10);
      1: return 32'd495 + $urandom_range(0, 10);
      2: return $urandom_range(0, 3000);
      3: return $urandom;
      default: return $urandom_range(1500, 6000);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; frame_end_i = 0; force_off_i = 0; draw_i = 0; collapsed_i = 0;
    repeat (2) @(negedge clk);
    do_reset();                          // R1
    step(0, 1, 0, 0);                    // R2 force while disabled: no effect
    step(1, 0, 2000, 0);                 // R4 exactly 2000 -> low load
    step(1, 0, 2001, 0);                 // R6 enable from low load
    step(0, 0, 9000, 9000);              // R10 hold without strobe
    step(1, 0, 3000, 500);               // R9 stays enabled
    step(1, 0, 3000, 499);               // R7 -> unoptimizable
    step(1, 0, 5000, 0);                 // R5 no re-enable
    step(1, 0, 100, 0);                  // R4 back to low load
    step(1, 0, 2500, 0);                 // R6 enable
    step(1, 0, 1500, 500);               // R8 priority: sum 2000, light
    step(1, 0, 2500, 0);                 // R6
    step(1, 0, 1000, 10);                // R8 over R7
    step(1, 0, 2500, 0);                 // R6
    step(1, 0, 32'hFFFF_FFFF, 32'd10);   // R7 no wrap in sum
    step(1, 0, 1, 0);                    // R4
    step(1, 0, 2500, 0);                 // R6
    step(1, 0, 32'hFFFF_FF00, 32'h200);  // R9 wide sum
    step(1, 1, 100, 0);                  // R2 force beats frame end
    step(1, 0, 9000, 0);                 // R3 sticky
    step(1, 0, 10, 0);                   // R3 sticky on light frame
    do_reset();                          // R1
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 199) == 0) do_reset();
      else step($urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0, pick(), pick());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule